// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register Bank

This block holds the digital codes for four converter channels. A host writes a code word over a parallel bus with an active-low chip select, a write/read select and a two-bit channel address; the word lands in the addressed channel's staging register when chip select returns high. A shared active-low load strobe, sampled on every clock, copies all four staging registers into the live code registers that drive the converters. All four channels update on the same edge.

Leaving the strobe high lets a host stage all four channels and then release them together with one low pulse. Holding the strobe low instead makes each written code reach its output one clock after it is staged. A read cycle returns the addressed staging register on a data-out bus with a separate output enable, which stands in for a tri-stated pin bus. An asynchronous clear forces every register to zero or to midscale, depending on a mode input.

Top module: `quad_dac_regbank`

## Requirements
- R1: While `clr_n` is low with `mid_sel` = 0, every staging register and every live code is 0.
- R2: While `clr_n` is low with `mid_sel` = 1, every staging register and every live code is midscale, which is only the top bit set (0x800 for 12 bits).
- R3: A write cycle (`cs_n` low with `wr_sel` = 1, then `cs_n` high) stores the `din` and `addr` seen in the last clock with `cs_n` low into that channel's staging register. The store happens on the first clock edge that samples `cs_n` high. Other channels are unchanged.
- R4: `dout_oe` is 1 only while `cs_n` is low and `wr_sel` = 0. It drops as soon as `cs_n` goes high, and it stays 0 throughout write cycles.
- R5: A read cycle changes no staging register and no live code.
- R6: While `ld_n` is sampled high, the live codes hold their values, whatever is written.
- R7: Each clock edge that samples `ld_n` low copies all four staging registers into the live codes on that same edge.
- R8: With `ld_n` held low, a written code appears on `code` one clock after the edge on which it is staged.
- R9: The clear acts asynchronously. Outputs take the clear value without any clock edge.
- R10: Address value i selects channel i. Channel i's live code sits at `code[i*DW +: DW]`. A read returns the staging register of the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mid_sel | input | 1 | Clear value select: 0 gives zero, 1 gives midscale |
| cs_n | input | 1 | Bus chip select, active low |
| wr_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | 2 | Channel address |
| din | input | 12 | Write data |
| ld_n | input | 1 | Load strobe, active low, level sensitive |
| dout | output | 12 | Read data |
| dout_oe | output | 1 | Read data enable; 0 means the bus is released |
| code | output | 48 | Four live codes, channel 0 in the low bits |

## Verification
A staging register written to the wrong channel or at the wrong edge is invisible on `code` while the strobe is high. It shows up on the very next read of any channel. The same fault reaches `code` on the first clock with the strobe low. A live code that updates while the strobe is high appears on `code` one clock after the offending edge. Clearing with each mode setting and checking the outputs before any clock edge exposes a wrong clear value, or a clear that waits for the clock.

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int DW  = 12,
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              mid_sel,
  input  logic              cs_n,
  input  logic              wr_sel,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  input  logic              ld_n,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  output logic [NCH*DW-1:0] code
);

  logic [DW-1:0]     clr_code;
  logic [NCH*DW-1:0] in_flat;
  logic              cs_q, hold_wr, commit;
  logic [AW-1:0]     hold_addr;
  logic [DW-1:0]     hold_data;

  assign clr_code = mid_sel ? {1'b1, {(DW-1){1'b0}}} : '0;
  assign commit   = cs_n & ~cs_q & hold_wr;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cs_q      <= 1'b1;
      hold_wr   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      cs_q <= cs_n;
      if (!cs_n) begin
        hold_wr   <= wr_sel;
        hold_addr <= addr;
        hold_data <= din;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] stage_q, live_q;

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
        stage_q <= clr_code;
      else if (commit && hold_addr == AW'(g))
        stage_q <= hold_data;
    end

    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
        live_q <= clr_code;
      else if (!ld_n)
        live_q <= stage_q;
    end

    assign in_flat[g*DW +: DW] = stage_q;
    assign code[g*DW +: DW]    = live_q;
  end

  assign dout_oe = ~cs_n & ~wr_sel;
  assign dout    = in_flat[addr*DW +: DW];

endmodule

module quad_dac_regbank_chk #(
  parameter int DW  = 12,
  parameter int NCH = 4,
  localparam int AW = $clog2(NCH)
) (
  input logic              clk,
  input logic              clr_n,
  input logic              cs_n,
  input logic              wr_sel,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     din,
  input logic              ld_n,
  input logic              dout_oe,
  input logic [NCH*DW-1:0] code,
  input logic [NCH*DW-1:0] in_flat
);

  assert_stage_only_on_release_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n && $past(cs_n)) |=> $stable(in_flat));

  assert_stage_lands_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n && !$past(cs_n) && $past(wr_sel)) |=>
      (in_flat[$past(addr, 2)*DW +: DW] == $past(din, 2)));

  assert_bus_released_R4: assert property (@(posedge clk) disable iff (!clr_n)
    cs_n |-> !dout_oe);

  assert_live_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
    ld_n |=> $stable(code));

  assert_live_load_R7: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (code == $past(in_flat)));

endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_sel(wr_sel), .addr(addr),
  .din(din), .ld_n(ld_n), .dout_oe(dout_oe), .code(code), .in_flat(in_flat)
);

// File: tb/quad_dac_regbank_tb.sv
module quad_dac_regbank_tb;
  localparam int DW = 12;
  localparam int NCH = 4;

  logic clk = 0, clr_n = 0, mid_sel = 0, cs_n = 1, wr_sel = 1, ld_n = 1;
  logic [1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dout_oe;
  logic [NCH*DW-1:0] code;

  int nchk = 0, nerr = 0;
  logic [DW-1:0] exp_in[NCH];
  logic [DW-1:0] exp_live[NCH];

  always #2.5 clk = ~clk;

  quad_dac_regbank u_dut (
    .clk(clk), .clr_n(clr_n), .mid_sel(mid_sel), .cs_n(cs_n), .wr_sel(wr_sel),
    .addr(addr), .din(din), .ld_n(ld_n), .dout(dout), .dout_oe(dout_oe), .code(code)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_live(string req);
    for (int i = 0; i < NCH; i++) chk(req, code[i*DW +: DW], exp_live[i]);
  endtask

  task automatic bus_write(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cs_n = 0; wr_sel = 1; addr = a; din = d;
    #1 chk("R4 enable during write", {11'b0, dout_oe}, 12'h0);
    @(negedge clk);
    cs_n = 1; din = ~d; addr = a + 2'd1;
    @(posedge clk); #1;
    exp_in[a] = d;
  endtask

  task automatic bus_read(logic [1:0] a, string req);
    @(negedge clk);
    cs_n = 0; wr_sel = 0; addr = a;
    #1;
    chk("R4 enable during read", {11'b0, dout_oe}, 12'h1);
    chk(req, dout, exp_in[a]);
    @(negedge clk);
    cs_n = 1; wr_sel = 1;
    #1 chk("R4 release after read", {11'b0, dout_oe}, 12'h0);
  endtask

  task automatic do_clear(logic mid, string req);
    logic [DW-1:0] v;
    v = mid ? 12'h800 : 12'h000;
    @(negedge clk);
    #1 mid_sel = mid; clr_n = 0;
    #0.5;
    for (int i = 0; i < NCH; i++) begin exp_in[i] = v; exp_live[i] = v; end
    chk_live({req, " R9 async clear"});
    @(negedge clk) clr_n = 1;
    for (int i = 0; i < NCH; i++) bus_read(2'(i), {req, " staging after clear"});
  endtask

  task automatic t_double_buffer();
    ld_n = 1;
    bus_write(2'd0, 12'h123);
    bus_write(2'd1, 12'h456);
    bus_write(2'd2, 12'h789);
    bus_write(2'd3, 12'hABC);
    @(posedge clk); #1 chk_live("R6 hold with strobe high");
    for (int i = 0; i < NCH; i++) bus_read(2'(i), "R10 readback per channel");
    @(negedge clk) ld_n = 0;
    @(posedge clk); #1;
    for (int i = 0; i < NCH; i++) exp_live[i] = exp_in[i];
    chk_live("R7 simultaneous load");
    @(negedge clk) ld_n = 1;
  endtask

  task automatic t_isolation();
    bus_write(2'd1, 12'hF0F);
    for (int i = 0; i < NCH; i++) bus_read(2'(i), "R3 only addressed channel");
    chk_live("R6 hold after lone write");
  endtask

  task automatic t_single_buffer();
    @(negedge clk) ld_n = 0;
    @(posedge clk); #1;
    for (int i = 0; i < NCH; i++) exp_live[i] = exp_in[i];
    bus_write(2'd2, 12'h5A5);
    chk("R8 one clock late", code[2*DW +: DW], exp_live[2]);
    @(posedge clk); #1;
    exp_live[2] = 12'h5A5;
    chk_live("R8 write reaches output");
    bus_write(2'd3, 12'h001);
    @(posedge clk); #1;
    exp_live[3] = 12'h001;
    chk_live("R8 second write");
    @(negedge clk) ld_n = 1;
  endtask

  task automatic t_read_no_effect();
    for (int i = 0; i < NCH; i++) bus_read(2'(3 - i), "R5 read pass");
    for (int i = 0; i < NCH; i++) bus_read(2'(i), "R5 staging after reads");
    @(negedge clk) ld_n = 0;
    @(posedge clk); #1 chk_live("R5 live after reads");
    @(negedge clk) ld_n = 1;
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    #1;
    for (int i = 0; i < NCH; i++) begin exp_in[i] = '0; exp_live[i] = '0; end
    chk_live("R1 initial clear");
    repeat (3) @(negedge clk);
    clr_n = 1;
    do_clear(1'b0, "R1");
    t_double_buffer();
    t_isolation();
    t_single_buffer();
    t_read_no_effect();
    do_clear(1'b1, "R2");
    t_double_buffer();
    do_clear(1'b0, "R1 again");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule